// File: doc/BRIEF.md
# CAN Received-Bit Sampler with Majority Voting

This block decides the logic value of every received CAN bit. The raw receive line first passes through a synchroniser. An external bit-timing unit supplies the timing as two single-cycle strobes. The time-quantum strobe marks each quantum and the sample-point strobe marks the decision instant of each bit. The block emits a one-cycle valid pulse carrying the decided bit, and downstream frame logic consumes that pulse.

The block has two sampling modes. In single mode the bit is the synchronised line level at the sample point. In triple mode the block also keeps the line values captured at the two most recent quantum strobes. The decided bit is then the majority of those two values and the current level.

The mode lives in a one-bit configuration register. A write to it takes effect only while the freeze input is high. Triple mode needs phase segment 1 to be at least two quanta long. If triple mode is selected with a shorter segment, the block samples in single mode and raises a sticky error flag.

Top module: `can_bit_sampler`

## Requirements
- R1: After reset the outputs are as follows: bit_valid is 0, config_err is 0 and smp_mode is 0 (single). Both history entries hold recessive 1, so a triple-mode decision made before any quantum strobe counts two votes of 1.
- R2: rx_in reaches the sampler through two flip-flops. A level driven on rx_in is used by a sample-point strobe asserted two or more cycles later. A strobe asserted one cycle later still uses the previous level.
- R3: In single sampling, a sample-point strobe in cycle t produces bit_valid=1 in cycle t+1 only. In that cycle bit_value equals the synchronised line level of cycle t. Between pulses bit_value keeps its last value.
- R4: In triple sampling the decided bit is 1 when at least two of the following three values are 1: the synchronised level at the strobe, and the values held by the history from the two most recent earlier quantum strobes.
- R5: smp_mode takes the value of cfg_triple (1 = triple, 0 = single) at a clock edge where both freeze and cfg_we are 1. A cfg_we pulse while freeze is 0 leaves smp_mode unchanged.
- R6: When smp_mode is 1 and pseg1 is below 2, sampling is single, even though smp_mode still reads 1.
- R7: config_err becomes 1 one cycle after any cycle in which smp_mode is 1 and pseg1 is below 2. Once set, it stays 1 until reset.
- R8: The history shifts in the synchronised level only on cycles with tq_stb=1. If a cycle has both strobes, the decision uses the history as it stood before that cycle's load. Without tq_stb the history does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Raw receive line |
| tq_stb | input | 1 | Time-quantum strobe |
| sp_stb | input | 1 | Sample-point strobe |
| freeze | input | 1 | Freeze mode, which enables configuration writes |
| cfg_we | input | 1 | Configuration write enable |
| cfg_triple | input | 1 | Mode value to write (1 = triple) |
| pseg1 | input | PSEG_W | Phase segment 1 length in quanta |
| bit_valid | output | 1 | One-cycle pulse marking a decided bit |
| bit_value | output | 1 | Decided bit value |
| smp_mode | output | 1 | Current sampling-mode register |
| config_err | output | 1 | Sticky error: triple mode with a short phase segment |

## Verification
A corrupted history entry flips bit_value only in triple mode, and only when the corrupted vote decides the majority. The bench therefore drives random line values together with dense quantum strobes, so that split votes occur often. Any mismatch shows in the cycle right after the affected sample-point strobe. A mode register that accepts a write outside freeze is visible on smp_mode one cycle after the write, and it later shows as single/triple mismatches. A broken error latch shows on config_err in the cycle after the bad combination, or in any later cycle where it drops back to 0.

// File: rtl/can_smp_pkg.sv
package can_smp_pkg;
   typedef enum logic {
      SMP_SINGLE = 1'b0,
      SMP_TRIPLE = 1'b1
   } smp_mode_e;

   localparam logic RECESSIVE = 1'b1;
endpackage

// File: rtl/can_rx_sync.sv
module can_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_sync
);
   import can_smp_pkg::*;

   logic [STAGES-1:0] stage_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("can_rx_sync needs at least two stages");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stage_q[i] <= RECESSIVE;
            else if (i == 0)
               stage_q[i] <= d_in;
            else
               stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/can_tq_history.sv
module can_tq_history #(
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             d_in,
   output logic [DEPTH-1:0] hist
);
   import can_smp_pkg::*;

   logic [DEPTH-1:0] hist_q;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("can_tq_history needs a depth of at least one");
      end
      if (DEPTH == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    hist_q <= {DEPTH{RECESSIVE}};
            else if (load) hist_q <= d_in;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    hist_q <= {DEPTH{RECESSIVE}};
            else if (load) hist_q <= {hist_q[DEPTH-2:0], d_in};
         end
      end
   endgenerate

   assign hist = hist_q;

   AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(hist_q)); // R8
endmodule

// File: rtl/can_smp_cfg.sv
module can_smp_cfg #(
   parameter int PSEG_W   = 3,
   parameter int MIN_PSEG = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              freeze,
   input  logic              cfg_we,
   input  logic              cfg_triple,
   input  logic [PSEG_W-1:0] pseg1,
   output logic              mode,
   output logic              triple_eff,
   output logic              err
);
   import can_smp_pkg::*;

   localparam logic [PSEG_W-1:0] MIN_PSEG_V = PSEG_W'(MIN_PSEG);

   smp_mode_e mode_q;
   logic      err_q;
   logic      seg_short;

   generate
      if (MIN_PSEG >= (1 << PSEG_W)) begin : g_bad_width
         $error("pseg1 width cannot express the minimum segment");
      end
   endgenerate

   assign seg_short = (pseg1 < MIN_PSEG_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= SMP_SINGLE;
      else if (freeze && cfg_we)
         mode_q <= cfg_triple ? SMP_TRIPLE : SMP_SINGLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err_q <= 1'b0;
      else if ((mode_q == SMP_TRIPLE) && seg_short)
         err_q <= 1'b1;
   end

   assign mode       = (mode_q == SMP_TRIPLE);
   assign triple_eff = mode && !seg_short;
   assign err        = err_q;

   AST_NO_WRITE_OUTSIDE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      !freeze |=> $stable(mode)); // R5
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err); // R7
   AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode && seg_short) |=> err); // R7
endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler #(
   parameter int PSEG_W      = 3,
   parameter int N_PRE       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_in,
   input  logic              tq_stb,
   input  logic              sp_stb,
   input  logic              freeze,
   input  logic              cfg_we,
   input  logic              cfg_triple,
   input  logic [PSEG_W-1:0] pseg1,
   output logic              bit_valid,
   output logic              bit_value,
   output logic              smp_mode,
   output logic              config_err
);
   localparam int VOTES = N_PRE + 1;
   localparam int CW    = $clog2(VOTES + 1);
   localparam logic [CW-1:0] NEED = CW'((VOTES + 1) / 2);

   logic             rx_s;
   logic [N_PRE-1:0] hist;
   logic             triple_eff;
   logic [CW-1:0]    ones;
   logic             vote_bit;
   logic             decided;
   logic             valid_q;
   logic             value_q;

   generate
      if (N_PRE < 2 || (N_PRE % 2) != 0) begin : g_bad_votes
         $error("N_PRE must be even and at least two");
      end
   endgenerate

   can_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(rx_in), .d_sync(rx_s)
   );

   can_tq_history #(.DEPTH(N_PRE)) u_hist (
      .clk(clk), .rst_n(rst_n), .load(tq_stb), .d_in(rx_s), .hist(hist)
   );

   can_smp_cfg #(.PSEG_W(PSEG_W), .MIN_PSEG(N_PRE)) u_cfg (
      .clk(clk), .rst_n(rst_n), .freeze(freeze), .cfg_we(cfg_we),
      .cfg_triple(cfg_triple), .pseg1(pseg1), .mode(smp_mode),
      .triple_eff(triple_eff), .err(config_err)
   );

   always_comb begin
      ones = CW'(rx_s);
      for (int i = 0; i < N_PRE; i++)
         ones = ones + CW'(hist[i]);
   end

   assign vote_bit = (ones >= NEED);
   assign decided  = triple_eff ? vote_bit : rx_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         value_q <= 1'b0;
      end else begin
         valid_q <= sp_stb;
         if (sp_stb) value_q <= decided;
      end
   end

   assign bit_valid = valid_q;
   assign bit_value = value_q;

   AST_VALID_FOLLOWS_SP: assert property (@(posedge clk) disable iff (!rst_n)
      sp_stb |=> bit_valid); // R3
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !sp_stb |=> !bit_valid); // R3
   AST_SINGLE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_stb && !triple_eff) |=> (bit_value == $past(rx_s))); // R6
   AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sp_stb |=> $stable(bit_value)); // R3
endmodule

// File: tb/can_bit_sampler_tb_top.sv
`timescale 1ns/1ps
module can_bit_sampler_tb_top;
   localparam int PSEG_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_in = 1'b1, tq_stb = 1'b0, sp_stb = 1'b0;
   logic freeze = 1'b0, cfg_we = 1'b0, cfg_triple = 1'b0;
   logic [PSEG_W-1:0] pseg1 = 3'd4;
   logic bit_valid, bit_value, smp_mode, config_err;

   int n_checks = 0;
   int n_fail   = 0;
   bit model_on = 1'b0;

   always #2 clk = ~clk;

   can_bit_sampler #(.PSEG_W(PSEG_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tq_stb(tq_stb),
      .sp_stb(sp_stb), .freeze(freeze), .cfg_we(cfg_we),
      .cfg_triple(cfg_triple), .pseg1(pseg1), .bit_valid(bit_valid),
      .bit_value(bit_value), .smp_mode(smp_mode), .config_err(config_err)
   );

   // behavioural reference
   bit m_s1, m_s2, m_mode, m_err, m_valid, m_value, m_trip;
   bit m_hist[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = 1; m_s2 = 1; m_mode = 0; m_err = 0;
         m_valid = 0; m_value = 0; m_trip = 0;
         m_hist = '{1, 1};
      end else begin
         bit dec;
         int votes;
         m_trip = m_mode && (pseg1 >= 2);
         votes  = int'(m_s2) + int'(m_hist[0]) + int'(m_hist[1]);
         dec    = m_trip ? (votes >= 2) : m_s2;
         m_valid = sp_stb;
         if (sp_stb) m_value = dec;
         if (m_mode && pseg1 < 2) m_err = 1;
         if (tq_stb) begin
            m_hist.push_front(m_s2);
            void'(m_hist.pop_back());
         end
         m_s2 = m_s1;
         m_s1 = rx_in;
         if (freeze && cfg_we) m_mode = cfg_triple;
      end
   end

   task automatic check(string tag, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (model_on && rst_n) begin
         check("R3 bit_valid", bit_valid, m_valid);
         check(m_trip ? "R4 bit_value" : "R3 bit_value", bit_value, m_value);
         check("R5 smp_mode", smp_mode, m_mode);
         check("R7 config_err", config_err, m_err);
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_mode(bit v, bit frz);
      @(negedge clk); freeze = frz; cfg_we = 1; cfg_triple = v;
      @(negedge clk); cfg_we = 0; freeze = 0;
   endtask

   task automatic tq_pulse();
      @(negedge clk); tq_stb = 1;
      @(negedge clk); tq_stb = 0;
   endtask

   task automatic sp_pulse();
      @(negedge clk); sp_stb = 1;
      @(negedge clk); sp_stb = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      tq_stb = 0; sp_stb = 0; freeze = 0; cfg_we = 0; rx_in = 1; pseg1 = 3'd4;
      idle(2); rst_n = 1;
   endtask

   initial begin
      idle(3);
      rst_n = 1;
      @(negedge clk);
      check("R1 bit_valid", bit_valid, 1'b0);
      check("R1 config_err", config_err, 1'b0);
      check("R1 smp_mode", smp_mode, 1'b0);
      model_on = 1;

      // R1: recessive history outvotes a dominant level
      rx_in = 0;
      write_mode(1, 1);
      check("R5 write in freeze", smp_mode, 1'b1);
      idle(2);
      sp_pulse();
      check("R1 recessive history vote", bit_value, 1'b1);

      // R8: load two dominant quanta, then no quantum strobes
      tq_pulse(); tq_pulse();
      rx_in = 1; idle(3);
      sp_pulse();
      check("R8 history vote", bit_value, 1'b0);
      sp_pulse();
      check("R8 history held without tq", bit_value, 1'b0);

      // R5: write outside freeze is ignored
      write_mode(0, 0);
      check("R5 write outside freeze ignored", smp_mode, 1'b1);

      // R2: synchroniser latency, single mode
      write_mode(0, 1);
      rx_in = 1; idle(3);
      @(negedge clk); rx_in = 0;
      @(negedge clk); sp_stb = 1;
      @(negedge clk); sp_stb = 0;
      check("R2 one cycle too early", bit_value, 1'b1);
      @(negedge clk); rx_in = 1;
      idle(1);
      @(negedge clk); sp_stb = 1;
      @(negedge clk); sp_stb = 0;
      check("R2 two cycles later", bit_value, 1'b1);
      rx_in = 0; idle(1);
      @(negedge clk); sp_stb = 1;
      @(negedge clk); sp_stb = 0;
      check("R2 two cycles later dominant", bit_value, 1'b0);

      // R6 / R7: short segment falls back to single, error latches
      write_mode(1, 1);
      rx_in = 0; idle(2);
      tq_pulse(); tq_pulse();
      rx_in = 1; pseg1 = 3'd1; idle(2);
      @(negedge clk); sp_stb = 1;
      @(negedge clk); sp_stb = 0;
      check("R6 fallback single", bit_value, 1'b1);
      check("R7 error set", config_err, 1'b1);
      pseg1 = 3'd5;
      write_mode(0, 1);
      idle(3);
      check("R7 error sticky", config_err, 1'b1);

      // random traffic
      do_reset();
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         rx_in  = 1'($urandom);
         sp_stb = ((c % 4) == 3);
         tq_stb = sp_stb || (($urandom % 4) != 0);
         freeze = (($urandom % 6) == 0);
         cfg_we = 1'($urandom);
         cfg_triple = (($urandom % 3) != 0);
         pseg1 = (c < 2500) ? PSEG_W'(2 + ($urandom % 6)) : PSEG_W'($urandom % 8);
      end
      @(negedge clk);
      tq_stb = 0; sp_stb = 0; freeze = 0; cfg_we = 0;
      idle(2);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule